// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block is the device-side command front end of a four-bank double-data-rate SDRAM. It samples chip select, the three active-low command strobes, clock enable, the bank address and the address bus on each rising clock edge. From these inputs it works out which command was issued. It keeps an open/idle flag and an open-row register for every bank, and it follows the power state of the device.

Each accepted command is reported one cycle later, together with its bank, its column, its auto-precharge flag and a flag for illegal use. The block also holds a copy of the mode register and the extended mode register. A surrounding memory model or protocol monitor can use these outputs to steer its data path and timing checks. The block does not model data, strobes, termination or refresh timing.

Top module: `sdram_front`

## Requirements
- R1: After synchronous reset the block shows all of the following: every bank idle, all open rows zero, power state normal (code 0), reported command NOP (code 0), the illegal flag low, and both mode copies zero.
- R2: When chip select is sampled high, the reported command is NOP and no bank or mode state changes, whatever the strobes carry.
- R3: The strobes {ras_n,cas_n,we_n} decode as follows: 011 ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 REFRESH when clock enable is high or SELF-REFRESH entry when it is low, and 000 mode set. Every other pattern is NOP. The command is reported on cmd_kind after the sampling edge with these codes: NOP 0, ACTIVE 1, READ 2, WRITE 3, PRECHARGE-one 4, PRECHARGE-all 5, REFRESH 6, SELF-REFRESH 7, mode set 8, extended mode set 9, mode set to an unused bank address 10.
- R4: ACTIVE to an idle bank opens it and stores addr[12:0] as that bank's open row, visible in open_rows at bit offset bank*13.
- R5: READ and WRITE report the bank, the column addr[9:0] on cmd_col and the auto-precharge flag addr[10] on cmd_auto_pre. Without auto-precharge the bank stays open.
- R6: PRECHARGE with addr[10] low closes only the bank given by ba and reports code 4. With addr[10] high it closes every bank and reports code 5.
- R7: A legal READ or WRITE with addr[10] high leaves its bank open after the command edge and closes it at the next edge.
- R8: These commands raise cmd_illegal and change no bank state: READ or WRITE to an idle bank, ACTIVE to an open bank, and SELF-REFRESH entry while any bank is open.
- R9: Clock enable sampled low in the normal state enters precharge power-down (code 1) if all banks are idle, or active power-down (code 2) if any bank is open. Clock enable sampled high in power-down returns the block to normal (code 0). Commands sampled while clock enable is low, or on the exit edge, are ignored.
- R10: SELF-REFRESH entry with all banks idle enters self refresh (code 3). While in self refresh, pwr_state reads normal as soon as clock enable goes high, without waiting for a clock edge.
- R11: A mode set with ba=0 stores addr into mode_reg, and one with ba=1 stores it into ext_mode_reg. A mode set with ba=2 or 3 changes neither copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row, column or mode operand |
| cmd_kind | output | 4 | Decoded command code (R3) |
| cmd_bank | output | 2 | Bank of the reported command |
| cmd_col | output | 10 | Column of a READ or WRITE |
| cmd_auto_pre | output | 1 | Auto-precharge flag of a READ or WRITE |
| cmd_illegal | output | 1 | Reported command was illegal |
| bank_open | output | 4 | Open flag per bank |
| open_rows | output | 52 | Open row per bank, 13 bits each |
| pwr_state | output | 2 | Power state code |
| mode_reg | output | 13 | Stored mode register |
| ext_mode_reg | output | 13 | Stored extended mode register |

## Verification
The hardest case to reach is the asynchronous exit from self refresh. The block has to be in self refresh with every bank idle, and clock enable then has to rise between two clock edges. The stimulus first closes all banks, then issues the refresh strobes with clock enable low. It raises clock enable one nanosecond after a falling edge and samples pwr_state before the next rising edge arrives. The auto-precharge close is also timing-sensitive, so the bench reads the bank flag at two successive falling edges after the command.

// File: rtl/sdfront_pkg.sv
`timescale 1ns/1ps
package sdfront_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_PRE  = 4'd4,
        CMD_PREA = 4'd5,
        CMD_REF  = 4'd6,
        CMD_SREF = 4'd7,
        CMD_MRS  = 4'd8,
        CMD_EMRS = 4'd9,
        CMD_MRSX = 4'd10
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_NORMAL = 2'd0,
        PWR_PRE_PD = 2'd1,
        PWR_ACT_PD = 2'd2,
        PWR_SELF   = 2'd3
    } pwr_e;

    typedef struct packed {
        cmd_e       kind;
        logic       illegal;
        logic       auto_pre;
    } cmd_info_t;

    // Strobe pattern {ras_n,cas_n,we_n} to command kind.
    function automatic cmd_e strobe_decode(
        input logic [2:0] rcw,
        input logic       cke_now,
        input logic       all_sel,
        input logic       sel_mr,
        input logic       sel_emr
    );
        cmd_e k;
        case (rcw)
            3'b011:  k = CMD_ACT;
            3'b101:  k = CMD_RD;
            3'b100:  k = CMD_WR;
            3'b010:  k = all_sel ? CMD_PREA : CMD_PRE;
            3'b001:  k = cke_now ? CMD_REF : CMD_SREF;
            3'b000:  k = sel_mr ? CMD_MRS : (sel_emr ? CMD_EMRS : CMD_MRSX);
            default: k = CMD_NOP;
        endcase
        return k;
    endfunction

    function automatic logic is_rdwr(input cmd_e k);
        return (k == CMD_RD) || (k == CMD_WR);
    endfunction

endpackage

// File: rtl/sdfront_decode.sv
`timescale 1ns/1ps
module sdfront_decode
    import sdfront_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10
) (
    input  logic              accept,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output cmd_e              kind
);
    cmd_e raw;

    always_comb begin
        raw = strobe_decode({ras_n, cas_n, we_n}, cke, addr[AP_BIT],
                            ba == BA_W'(0), ba == BA_W'(1));
        kind = CMD_NOP;
        if (accept && !cs_n) begin
            // with clock enable low only self-refresh entry is taken
            if (cke || raw == CMD_SREF) begin
                kind = raw;
            end
        end
    end
endmodule

// File: rtl/sdfront_bank.sv
`timescale 1ns/1ps
module sdfront_bank #(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_en,
    input  logic             close_en,
    input  logic             ap_en,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] row_q
);
    logic ap_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open <= 1'b0;
            row_q   <= '0;
            ap_pend <= 1'b0;
        end else begin
            ap_pend <= ap_en;
            if (act_en) begin
                is_open <= 1'b1;
                row_q   <= row_in;
            end else if (close_en || ap_pend) begin
                is_open <= 1'b0;
            end
        end
    end

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
        act_en |=> (is_open && row_q == $past(row_in))); // R4

    AST_AP_CLOSES: assert property (@(posedge clk) disable iff (rst)
        ap_en |-> ##2 !is_open); // R7

    AST_AP_STAYS: assert property (@(posedge clk) disable iff (rst)
        (ap_en && !close_en) |=> is_open); // R7
endmodule

// File: rtl/sdfront_power.sv
`timescale 1ns/1ps
module sdfront_power
    import sdfront_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  cmd_e kind,
    input  logic any_open,
    output logic accept,
    output pwr_e view
);
    pwr_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_NORMAL: if (!cke) begin
                if (kind == CMD_SREF && !any_open) state_d = PWR_SELF;
                else if (any_open)                  state_d = PWR_ACT_PD;
                else                                state_d = PWR_PRE_PD;
            end
            PWR_PRE_PD, PWR_ACT_PD, PWR_SELF:
                if (cke) state_d = PWR_NORMAL;
            default: state_d = PWR_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PWR_NORMAL;
        else     state_q <= state_d;
    end

    assign accept = (state_q == PWR_NORMAL);
    // self-refresh exit seen from clock enable without an edge
    assign view   = (state_q == PWR_SELF && cke) ? PWR_NORMAL : state_q;

    AST_SELF_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == PWR_SELF && $past(state_q) == PWR_NORMAL) |-> !$past(any_open)); // R10

    AST_PD_KIND: assert property (@(posedge clk) disable iff (rst)
        (state_q == PWR_PRE_PD && $past(state_q) == PWR_NORMAL) |-> !$past(any_open)); // R9

    AST_WAKE: assert property (@(posedge clk) disable iff (rst)
        (state_q != PWR_NORMAL && cke) |=> state_q == PWR_NORMAL); // R9
endmodule

// File: rtl/sdram_front.sv
`timescale 1ns/1ps
module sdram_front
    import sdfront_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int AP_BIT    = 10,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cke,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [BA_W-1:0]            ba,
    input  logic [ADDR_W-1:0]          addr,
    output logic [3:0]                 cmd_kind,
    output logic [BA_W-1:0]            cmd_bank,
    output logic [COL_W-1:0]           cmd_col,
    output logic                       cmd_auto_pre,
    output logic                       cmd_illegal,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows,
    output logic [1:0]                 pwr_state,
    output logic [ADDR_W-1:0]          mode_reg,
    output logic [ADDR_W-1:0]          ext_mode_reg
);
    cmd_e      kind;
    logic      accept;
    pwr_e      pwr_view;
    logic      any_open;
    logic      sel_open;
    cmd_info_t info_d, info_q;
    logic [BA_W-1:0]  bank_q;
    logic [COL_W-1:0] col_q;
    logic             past_ok;

    sdfront_decode #(.BA_W(BA_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_dec (
        .accept(accept), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .kind(kind)
    );

    assign any_open = |bank_open;
    assign sel_open = bank_open[ba];

    always_comb begin
        info_d.kind     = kind;
        info_d.illegal  = (is_rdwr(kind) && !sel_open)
                        || (kind == CMD_ACT && sel_open)
                        || (kind == CMD_SREF && any_open);
        info_d.auto_pre = is_rdwr(kind) && addr[AP_BIT];
    end

    sdfront_power u_pwr (
        .clk(clk), .rst(rst), .cke(cke), .kind(kind),
        .any_open(any_open), .accept(accept), .view(pwr_view)
    );

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic hit;
        logic [ROW_W-1:0] row_i;
        assign hit = (ba == BA_W'(i));
        sdfront_bank #(.ROW_W(ROW_W)) u_bank (
            .clk(clk), .rst(rst),
            .act_en(hit && kind == CMD_ACT && !info_d.illegal),
            .close_en(kind == CMD_PREA || (hit && kind == CMD_PRE)),
            .ap_en(hit && info_d.auto_pre && !info_d.illegal),
            .row_in(addr[ROW_W-1:0]),
            .is_open(bank_open[i]),
            .row_q(row_i)
        );
        assign open_rows[i*ROW_W +: ROW_W] = row_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            info_q       <= '{kind: CMD_NOP, illegal: 1'b0, auto_pre: 1'b0};
            bank_q       <= '0;
            col_q        <= '0;
            mode_reg     <= '0;
            ext_mode_reg <= '0;
            past_ok      <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            info_q  <= info_d;
            bank_q  <= (kind == CMD_NOP) ? '0 : ba;
            col_q   <= is_rdwr(kind) ? addr[COL_W-1:0] : '0;
            if (kind == CMD_MRS)  mode_reg     <= addr;
            if (kind == CMD_EMRS) ext_mode_reg <= addr;
        end
    end

    assign cmd_kind     = info_q.kind;
    assign cmd_illegal  = info_q.illegal;
    assign cmd_auto_pre = info_q.auto_pre;
    assign cmd_bank     = bank_q;
    assign cmd_col      = col_q;
    assign pwr_state    = pwr_view;

    AST_CS_MASK: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(cs_n)) |-> info_q.kind == CMD_NOP); // R2

    AST_PREA_ALL: assert property (@(posedge clk) disable iff (rst)
        (info_q.kind == CMD_PREA) |-> bank_open == '0); // R6

    AST_MR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (past_ok && info_q.kind != CMD_MRS) |-> $stable(mode_reg)); // R11
endmodule

// File: tb/sdram_front_bench.sv
`timescale 1ns/1ps
module sdram_front_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [3:0]  cmd_kind;
    logic [1:0]  cmd_bank;
    logic [9:0]  cmd_col;
    logic        cmd_auto_pre, cmd_illegal;
    logic [3:0]  bank_open;
    logic [51:0] open_rows;
    logic [1:0]  pwr_state;
    logic [12:0] mode_reg, ext_mode_reg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sdram_front u_sdram_front (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_kind(cmd_kind), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .cmd_auto_pre(cmd_auto_pre), .cmd_illegal(cmd_illegal),
        .bank_open(bank_open), .open_rows(open_rows), .pwr_state(pwr_state),
        .mode_reg(mode_reg), .ext_mode_reg(ext_mode_reg)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive one command for one edge; return at the following falling edge
    task automatic issue(input logic c, input logic [2:0] rcw, input logic [1:0] b,
                         input logic [12:0] a, input logic ck);
        cs_n = c; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a; cke = ck;
        @(negedge clk);
        cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111;
    endtask

    function automatic int row_of(input int b);
        return int'(open_rows[b*13 +: 13]);
    endfunction

    task automatic t_reset;
        chk("R1", "kind", cmd_kind, 0);
        chk("R1", "open", bank_open, 0);
        chk("R1", "pwr", pwr_state, 0);
        chk("R1", "illegal", cmd_illegal, 0);
        chk("R1", "mode", mode_reg, 0);
        chk("R1", "ext", ext_mode_reg, 0);
        chk("R1", "rows", int'(open_rows[31:0]), 0);
    endtask

    task automatic t_cs_mask;
        issue(1'b1, 3'b011, 2'd1, 13'h0AAA, 1'b1);
        chk("R2", "kind", cmd_kind, 0);
        chk("R2", "open", bank_open, 0);
        issue(1'b1, 3'b000, 2'd0, 13'h0055, 1'b1);
        chk("R2", "mode", mode_reg, 0);
    endtask

    task automatic t_activate;
        issue(1'b0, 3'b011, 2'd2, 13'h1ABC, 1'b1);
        chk("R3", "kind act", cmd_kind, 1);
        chk("R4", "bank", cmd_bank, 2);
        chk("R4", "open", bank_open, 4'b0100);
        chk("R4", "row", row_of(2), 13'h1ABC);
    endtask

    task automatic t_rdwr;
        issue(1'b0, 3'b101, 2'd2, 13'h0155, 1'b1);
        chk("R3", "kind rd", cmd_kind, 2);
        chk("R5", "col", cmd_col, 10'h155);
        chk("R5", "ap", cmd_auto_pre, 0);
        chk("R5", "illegal", cmd_illegal, 0);
        issue(1'b0, 3'b100, 2'd2, 13'h02AA, 1'b1);
        chk("R3", "kind wr", cmd_kind, 3);
        chk("R5", "col wr", cmd_col, 10'h2AA);
        @(negedge clk);
        chk("R5", "still open", bank_open, 4'b0100);
    endtask

    task automatic t_illegal;
        issue(1'b0, 3'b101, 2'd0, 13'h0001, 1'b1);
        chk("R8", "rd idle flag", cmd_illegal, 1);
        chk("R8", "rd idle open", bank_open, 4'b0100);
        issue(1'b0, 3'b011, 2'd2, 13'h0011, 1'b1);
        chk("R8", "act open flag", cmd_illegal, 1);
        chk("R8", "row kept", row_of(2), 13'h1ABC);
        issue(1'b0, 3'b100, 2'd3, 13'h0401, 1'b1);
        @(negedge clk);
        chk("R8", "wr idle ap no open", bank_open, 4'b0100);
    endtask

    task automatic t_precharge;
        issue(1'b0, 3'b011, 2'd1, 13'h0005, 1'b1);
        issue(1'b0, 3'b010, 2'd2, 13'h0000, 1'b1);
        chk("R6", "kind pre", cmd_kind, 4);
        chk("R6", "one closed", bank_open, 4'b0010);
        issue(1'b0, 3'b011, 2'd3, 13'h0009, 1'b1);
        chk("R6", "two open", bank_open, 4'b1010);
        issue(1'b0, 3'b010, 2'd0, 13'h0400, 1'b1);
        chk("R6", "kind prea", cmd_kind, 5);
        chk("R6", "all closed", bank_open, 0);
    endtask

    task automatic t_autopre;
        issue(1'b0, 3'b011, 2'd0, 13'h0007, 1'b1);
        issue(1'b0, 3'b101, 2'd0, 13'h0403, 1'b1);
        chk("R7", "ap flag", cmd_auto_pre, 1);
        chk("R7", "col", cmd_col, 3);
        chk("R7", "open after cmd", bank_open, 4'b0001);
        @(negedge clk);
        chk("R7", "closed next", bank_open, 0);
    endtask

    task automatic t_mode;
        issue(1'b0, 3'b000, 2'd0, 13'h0123, 1'b1);
        chk("R11", "kind mrs", cmd_kind, 8);
        chk("R11", "mode", mode_reg, 13'h0123);
        issue(1'b0, 3'b000, 2'd1, 13'h0456, 1'b1);
        chk("R11", "kind emrs", cmd_kind, 9);
        chk("R11", "ext", ext_mode_reg, 13'h0456);
        issue(1'b0, 3'b000, 2'd2, 13'h0777, 1'b1);
        chk("R11", "kind other", cmd_kind, 10);
        chk("R11", "mode kept", mode_reg, 13'h0123);
        chk("R11", "ext kept", ext_mode_reg, 13'h0456);
        issue(1'b0, 3'b001, 2'd0, 13'h0000, 1'b1);
        chk("R3", "kind ref", cmd_kind, 6);
    endtask

    task automatic t_powerdown;
        issue(1'b1, 3'b111, 2'd0, 13'h0000, 1'b0);
        chk("R9", "pre pd", pwr_state, 1);
        issue(1'b0, 3'b011, 2'd1, 13'h0044, 1'b0);
        chk("R9", "act ignored", bank_open, 0);
        chk("R9", "kind nop", cmd_kind, 0);
        issue(1'b0, 3'b011, 2'd1, 13'h0044, 1'b1);
        chk("R9", "exit", pwr_state, 0);
        chk("R9", "exit cmd ignored", bank_open, 0);
        issue(1'b0, 3'b011, 2'd1, 13'h0044, 1'b1);
        issue(1'b1, 3'b111, 2'd0, 13'h0000, 1'b0);
        chk("R9", "act pd", pwr_state, 2);
        issue(1'b1, 3'b111, 2'd0, 13'h0000, 1'b1);
        chk("R9", "exit act pd", pwr_state, 0);
        chk("R9", "bank kept", bank_open, 4'b0010);
    endtask

    task automatic t_selfref;
        issue(1'b0, 3'b001, 2'd0, 13'h0000, 1'b0);
        chk("R8", "sref open flag", cmd_illegal, 1);
        chk("R8", "sref open pwr", pwr_state, 2);
        issue(1'b1, 3'b111, 2'd0, 13'h0000, 1'b1);
        issue(1'b0, 3'b010, 2'd0, 13'h0400, 1'b1);
        issue(1'b0, 3'b001, 2'd0, 13'h0000, 1'b0);
        chk("R10", "kind sref", cmd_kind, 7);
        chk("R10", "in self", pwr_state, 3);
        @(negedge clk);
        chk("R10", "held", pwr_state, 3);
        #1 cke = 1'b1;
        #0.5;
        chk("R10", "async exit", pwr_state, 0);
        @(negedge clk);
        chk("R10", "normal after edge", pwr_state, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_cs_mask;
        t_activate;
        t_rdwr;
        t_illegal;
        t_precharge;
        t_autopre;
        t_mode;
        t_powerdown;
        t_selfref;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule